// File: doc/BRIEF.md
# Segmented SPI Flash Master

This block drives an SPI flash bus for one logical transaction that arrives as a series of smaller sub-transactions. Each sub-transaction is sized to fit one host packet. Each command gives a write byte count, a read byte count and a flag marking the final piece. Within a piece, every write byte is shifted out before any read byte is clocked in. Chip select stays low from one piece to the next, so the flash sees one unbroken transaction no matter how many pieces it takes.

Write bytes enter on a valid/ready stream and read bytes leave on another. When a write byte is missing, or the read output still holds a byte nobody has taken, the bus clock waits low at a byte boundary. Chip select stays asserted during the wait, and the clock resumes when the stream is ready. Each piece ends with a one-cycle done pulse and a 16-bit status. The status can report success, a bad byte count, or a timeout on a stuck piece.

The bus runs in SPI mode 0, most significant bit first. The serial clock comes from the system clock through a programmable half-period divider.

Top module: `spi_seg_master`

## Requirements
- R1: In every sub-transaction, all write bytes go out on spi_mosi before any read byte is clocked in. Bytes are sent MSB first in mode 0: spi_mosi changes only while spi_sclk is low, and spi_miso is sampled on the rising edge. Read-phase bytes drive spi_mosi low.
- R2: After a successful sub-transaction with cmd_last = 0 that moved at least one byte, spi_cs_n is still low when done pulses. After one with cmd_last = 1, spi_cs_n is high when done pulses.
- R3: While waiting for a write byte, or for the read output to have room, spi_sclk holds low and spi_cs_n holds low. The clock resumes with no change to spi_cs_n.
- R4: spi_cs_n falls when a sub-transaction with bytes is accepted while the bus is idle. It falls at least half_div+1 system cycles before the first rising spi_sclk edge. It rises at least half_div+1 cycles after the last falling edge.
- R5: spi_sclk idles low whenever spi_cs_n is high. Each high phase of spi_sclk lasts exactly half_div+1 system cycles.
- R6: A sub-transaction with zero write and zero read bytes makes no clock edge. With cmd_last = 1 it only raises a held chip select. With cmd_last = 0 it leaves chip select as it was. Either way it reports status 0x0000.
- R7: A read count above 60 is rejected with status 0x0004, even if the write count is also bad. Otherwise, a write count above 60 is rejected with status 0x0003. A rejected command makes no clock edge and leaves spi_cs_n high.
- R8: If tmo_limit is nonzero and a sub-transaction is not finished tmo_limit cycles after it is accepted, done pulses with status 0x0001 and spi_cs_n is high. A tmo_limit of 0 turns the timeout off.
- R9: After reset, spi_cs_n = 1, spi_sclk = 0, cmd_ready = 1, done = 0 and rd_valid = 0.
- R10: Read bytes appear in bus order. Each one holds on rd_data with rd_valid high until rd_ready takes it. A successful sub-transaction reports status 0x0000 with a single-cycle done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_div | input | DIV_W | SCLK half period, in system cycles minus one |
| tmo_limit | input | TMO_W | Cycle budget per sub-transaction; 0 turns the timeout off |
| cmd_valid | input | 1 | Sub-transaction command present |
| cmd_ready | output | 1 | Engine idle, command will be taken |
| cmd_wr_cnt | input | CNT_W | Write bytes in this sub-transaction |
| cmd_rd_cnt | input | CNT_W | Read bytes in this sub-transaction |
| cmd_last | input | 1 | Release chip select when this piece ends |
| wr_data | input | 8 | Write byte |
| wr_valid | input | 1 | Write byte present |
| wr_ready | output | 1 | Engine takes the write byte |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | Read byte present |
| rd_ready | input | 1 | Consumer takes the read byte |
| done | output | 1 | One-cycle end-of-piece pulse |
| status | output | 16 | Result code, valid while done is high |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
Two events can land in the same cycle. The consumer may take the previous read byte on rd_ready in exactly the cycle the engine decides whether to start the next read byte. A read byte may also complete in the cycle the old one leaves. The bench provokes both by toggling rd_ready at random against the fastest divider settings. It judges them by comparing every read byte, in order, against the pattern the bus model returned, so a lost or doubled byte shows up as a mismatch.

// File: rtl/spi_seg_pkg.sv
package spi_seg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_NEXT,
    ST_LOW,
    ST_HIGH,
    ST_HOLD,
    ST_DONE
  } seg_state_t;

  localparam logic [15:0] STS_OK      = 16'h0000;
  localparam logic [15:0] STS_TIMEOUT = 16'h0001;
  localparam logic [15:0] STS_WR_BAD  = 16'h0003;
  localparam logic [15:0] STS_RD_BAD  = 16'h0004;

  // Count screening: read limit is checked before write limit.
  function automatic logic [15:0] count_status(input logic [31:0] wr, input logic [31:0] rd,
                                               input logic [31:0] max_wr, input logic [31:0] max_rd);
    if (rd > max_rd) return STS_RD_BAD;
    if (wr > max_wr) return STS_WR_BAD;
    return STS_OK;
  endfunction

endpackage

// File: rtl/spi_seg_halfper.sv
module spi_seg_halfper #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/spi_seg_tmo.sv
module spi_seg_tmo #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  logic [TMO_W-1:0] cnt;

  assign expired = run && (limit != '0) && (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (clear)                 cnt <= '0;
    else if (run && (cnt != '1))    cnt <= cnt + TMO_W'(1);
  end
endmodule

// File: rtl/spi_seg_shreg.sv
module spi_seg_shreg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       sample,
  input  logic       shift,
  input  logic       miso,
  output logic       mosi,
  output logic [7:0] next_byte
);
  logic [7:0] sreg;
  logic       samp;

  assign mosi      = sreg[7];
  assign next_byte = {sreg[6:0], samp};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
      samp <= 1'b0;
    end else begin
      if (load)        sreg <= load_byte;
      else if (shift)  sreg <= next_byte;
      if (sample)      samp <= miso;
    end
  end
endmodule

// File: rtl/spi_seg_master.sv
module spi_seg_master
  import spi_seg_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int CNT_W  = 7,
  parameter int TMO_W  = 16,
  parameter int MAX_WR = 60,
  parameter int MAX_RD = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] half_div,
  input  logic [TMO_W-1:0] tmo_limit,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [CNT_W-1:0] cmd_wr_cnt,
  input  logic [CNT_W-1:0] cmd_rd_cnt,
  input  logic             cmd_last,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic             done,
  output logic [15:0]      status,
  output logic             spi_cs_n,
  output logic             spi_sclk,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  localparam logic [2:0] LAST_BIT = 3'd7;

  seg_state_t       state;
  logic [CNT_W-1:0] wr_left, rd_left;
  logic [2:0]       bit_idx;
  logic             last_q, cs_q, sclk_q, reading_q;
  logic [15:0]      status_q;
  logic [7:0]       rd_data_q;
  logic             rd_valid_q;

  // Named internal events
  logic        accept, busy, phase_run, tick, tmo_hit;
  logic        load_wr, start_rd, rd_room, byte_end, rd_push;
  logic        rise_now, fall_now, mosi_bit;
  logic [7:0]  shifted;
  logic [15:0] chk;

  assign cmd_ready = (state == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign chk       = count_status(32'(cmd_wr_cnt), 32'(cmd_rd_cnt), 32'(MAX_WR), 32'(MAX_RD));
  assign busy      = (state == ST_SETUP) || (state == ST_NEXT) || (state == ST_LOW) ||
                     (state == ST_HIGH) || (state == ST_HOLD);
  assign phase_run = (state == ST_SETUP) || (state == ST_LOW) || (state == ST_HIGH) ||
                     (state == ST_HOLD);

  assign wr_ready = (state == ST_NEXT) && (wr_left != '0) && !tmo_hit;
  assign load_wr  = wr_ready && wr_valid;
  assign rd_room  = !rd_valid_q || rd_ready;
  assign start_rd = (state == ST_NEXT) && (wr_left == '0) && (rd_left != '0) && rd_room && !tmo_hit;
  assign rise_now = (state == ST_LOW) && tick && !tmo_hit;
  assign fall_now = (state == ST_HIGH) && tick && !tmo_hit;
  assign byte_end = fall_now && (bit_idx == LAST_BIT);
  assign rd_push  = byte_end && reading_q;

  spi_seg_halfper #(.DIV_W(DIV_W)) u_half (
    .clk(clk), .rst_n(rst_n), .run(phase_run), .div(half_div), .tick(tick));

  spi_seg_tmo #(.TMO_W(TMO_W)) u_tmo (
    .clk(clk), .rst_n(rst_n), .clear(accept), .run(busy), .limit(tmo_limit), .expired(tmo_hit));

  spi_seg_shreg u_shreg (
    .clk(clk), .rst_n(rst_n), .load(load_wr || start_rd),
    .load_byte(load_wr ? wr_data : 8'h00), .sample(rise_now), .shift(fall_now),
    .miso(spi_miso), .mosi(mosi_bit), .next_byte(shifted));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      wr_left   <= '0;
      rd_left   <= '0;
      bit_idx   <= '0;
      last_q    <= 1'b0;
      cs_q      <= 1'b0;
      sclk_q    <= 1'b0;
      reading_q <= 1'b0;
      status_q  <= STS_OK;
    end else if (tmo_hit) begin
      cs_q     <= 1'b0;
      sclk_q   <= 1'b0;
      status_q <= STS_TIMEOUT;
      state    <= ST_DONE;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          last_q   <= cmd_last;
          wr_left  <= cmd_wr_cnt;
          rd_left  <= cmd_rd_cnt;
          status_q <= chk;
          if (chk != STS_OK) begin
            cs_q  <= 1'b0;
            state <= ST_DONE;
          end else if ((cmd_wr_cnt == '0) && (cmd_rd_cnt == '0)) begin
            state <= (cmd_last && cs_q) ? ST_HOLD : ST_DONE;
          end else if (!cs_q) begin
            cs_q  <= 1'b1;
            state <= ST_SETUP;
          end else begin
            state <= ST_NEXT;
          end
        end
        ST_SETUP: if (tick) state <= ST_NEXT;
        ST_NEXT: begin
          if (load_wr) begin
            wr_left   <= wr_left - CNT_W'(1);
            reading_q <= 1'b0;
            bit_idx   <= '0;
            state     <= ST_LOW;
          end else if (start_rd) begin
            rd_left   <= rd_left - CNT_W'(1);
            reading_q <= 1'b1;
            bit_idx   <= '0;
            state     <= ST_LOW;
          end else if ((wr_left == '0) && (rd_left == '0)) begin
            state <= last_q ? ST_HOLD : ST_DONE;
          end
        end
        ST_LOW: if (tick) begin
          sclk_q <= 1'b1;
          state  <= ST_HIGH;
        end
        ST_HIGH: if (tick) begin
          sclk_q <= 1'b0;
          if (bit_idx == LAST_BIT) state <= ST_NEXT;
          else begin
            bit_idx <= bit_idx + 3'd1;
            state   <= ST_LOW;
          end
        end
        ST_HOLD: if (tick) begin
          cs_q  <= 1'b0;
          state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else if (rd_push) begin
      rd_valid_q <= 1'b1;
      rd_data_q  <= shifted;
    end else if (rd_ready) begin
      rd_valid_q <= 1'b0;
    end
  end

  assign rd_data  = rd_data_q;
  assign rd_valid = rd_valid_q;
  assign done     = (state == ST_DONE);
  assign status   = status_q;
  assign spi_cs_n = !cs_q;
  assign spi_sclk = sclk_q;
  assign spi_mosi = cs_q && mosi_bit && !reading_q;

  // Read bytes complete only after the write count of the piece is used up.
  a_r1_reads_after_writes: assert property (@(posedge clk) disable iff (!rst_n)
    rd_push |-> (wr_left == '0));

  a_r2_cs_kept_between: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !last_q && (status_q == STS_OK) && ($past(state) != ST_IDLE)) |-> cs_q);

  a_r3_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_NEXT) |-> (!sclk_q && cs_q));

  a_r5_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_q |-> !sclk_q);

  a_r5_sclk_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q != $past(sclk_q)) |-> ($past(tick) || $past(tmo_hit)));

  a_r7_error_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (status_q != STS_OK)) |-> !cs_q);

  a_r8_timeout_ends: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> (done && (status_q == STS_TIMEOUT)));

  a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_q && !rd_ready) |=> (rd_valid_q && $stable(rd_data_q)));

  a_r10_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    rd_push |-> rd_room);
endmodule

// File: tb/spi_seg_master_tb_top.sv
module spi_seg_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  half_div;
  logic [15:0] tmo_limit;
  logic        cmd_valid, cmd_ready, cmd_last;
  logic [6:0]  cmd_wr_cnt, cmd_rd_cnt;
  logic [7:0]  wr_data, rd_data;
  logic        wr_valid, wr_ready, rd_valid, rd_ready, done;
  logic [15:0] status;
  logic        spi_cs_n, spi_sclk, spi_mosi, spi_miso;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  spi_seg_master dut_i (
    .clk(clk), .rst_n(rst_n), .half_div(half_div), .tmo_limit(tmo_limit),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_wr_cnt(cmd_wr_cnt),
    .cmd_rd_cnt(cmd_rd_cnt), .cmd_last(cmd_last), .wr_data(wr_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .done(done), .status(status), .spi_cs_n(spi_cs_n),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  // Flash-side model: returns a fixed pattern per global byte number.
  function automatic logic [7:0] slv_pat(input int unsigned n);
    return 8'((n * 37) + 11);
  endfunction

  int unsigned slv_bytes = 0;
  logic [2:0]  slv_bit = 3'd0;
  logic [7:0]  slv_rx = 8'h00;
  logic [7:0]  slv_tx;
  logic [7:0]  mosi_log [1024];
  int unsigned rises = 0;

  always_comb slv_tx = slv_pat(slv_bytes);
  assign spi_miso = slv_tx[~slv_bit];

  always @(posedge spi_sclk) begin
    rises = rises + 1;
    if (!spi_cs_n) begin
      slv_rx = {slv_rx[6:0], spi_mosi};
      if (slv_bit == 3'd7) begin
        mosi_log[slv_bytes % 1024] = slv_rx;
        slv_bytes = slv_bytes + 1;
        slv_bit = 3'd0;
      end else slv_bit = slv_bit + 3'd1;
    end
  end
  always @(posedge spi_cs_n) slv_bit = 3'd0;

  // Timing measurement in system cycles
  int unsigned cyc = 0;
  int unsigned t_cs_fall = 0, t_rise = 0, t_fall = 0;
  int unsigned setup_len = 0, high_len = 0, hold_len = 0;
  bit first_pending = 0;
  always @(posedge clk) cyc = cyc + 1;
  always @(negedge spi_cs_n) begin t_cs_fall = cyc; first_pending = 1; end
  always @(posedge spi_sclk) begin
    t_rise = cyc;
    if (first_pending) begin setup_len = cyc - t_cs_fall; first_pending = 0; end
  end
  always @(negedge spi_sclk) begin t_fall = cyc; high_len = cyc - t_rise; end
  always @(posedge spi_cs_n) hold_len = cyc - t_fall;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  bit          cs_model = 0;
  int unsigned exp_bytes = 0;
  logic [7:0]  wbuf [128];
  logic [7:0]  rlog [128];

  task automatic run_sub(input int wr, input int rd, input bit last, input int stall_at,
                         input int stall_len, input logic [15:0] exp_sts, input string req);
    int wi = 0, ri = 0, iter = 0, stall_left = 0, snap = 0;
    bit got_done = 0, hs_w = 0, hs_r = 0, stalled = 0, snap_taken = 0, early_rd = 0;
    logic [15:0] sts = 16'hffff;
    logic        cs_at_done = 1'b0;
    int          bad = 0;
    for (int i = 0; i < wr; i++) wbuf[i] = 8'($urandom);
    @(negedge clk);
    cmd_valid = 1; cmd_wr_cnt = 7'(wr); cmd_rd_cnt = 7'(rd); cmd_last = last;
    @(negedge clk);
    cmd_valid = 0;
    while (!(got_done && (ri >= rd || sts != 16'h0)) && iter < 30000) begin
      if (iter != 0) @(negedge clk);
      iter++;
      if (hs_w) wi++;
      if (hs_r) begin ri++; if (wi < wr) early_rd = 1; end
      if (done && !got_done) begin got_done = 1; sts = status; cs_at_done = spi_cs_n; end
      if (!stalled && wi == stall_at) begin stalled = 1; stall_left = stall_len; end
      if (stall_left > 0) begin
        stall_left--;
        if (wr_ready && !snap_taken) begin snap_taken = 1; snap = int'(rises); end
        if (stall_left == 0 && snap_taken && !got_done) begin
          // R3: clock frozen and chip select held across the stall
          check(int'(rises) == snap, "R3", "sclk edges during stall", int'(rises), snap);
          check(spi_cs_n == 1'b0, "R3", "cs during stall", spi_cs_n, 0);
        end
      end
      wr_valid = (wi < wr) && (stall_left == 0) && ($urandom_range(0, 3) != 0);
      wr_data  = wbuf[wi % 128];
      rd_ready = ($urandom_range(0, 1) == 1);
      #1;
      hs_w = wr_valid && wr_ready;
      hs_r = rd_valid && rd_ready;
      if (hs_r) rlog[ri % 128] = rd_data;
    end
    wr_valid = 0; rd_ready = 0;
    check(got_done, req, "done seen", got_done, 1);
    check(sts == exp_sts, req, "status", sts, exp_sts);
    if (exp_sts != 16'h0) cs_model = 0;
    else if (last) cs_model = 0;
    else if (wr + rd > 0) cs_model = 1;
    // R2: chip select level at the done pulse
    check(cs_at_done == !cs_model, "R2", "cs at done", cs_at_done, !cs_model);
    if (exp_sts == 16'h0) begin
      for (int i = 0; i < wr; i++)
        if (mosi_log[(exp_bytes + i) % 1024] != wbuf[i]) bad++;
      check(bad == 0, "R1", "mosi byte mismatches", bad, 0);
      bad = 0;
      for (int j = 0; j < rd; j++)
        if (rlog[j] != slv_pat(exp_bytes + wr + j)) bad++;
      check(bad == 0, "R10", "read byte mismatches", bad, 0);
      check(!early_rd, "R1", "read before writes done", early_rd, 0);
      exp_bytes = exp_bytes + wr + rd;
    end else exp_bytes = slv_bytes;
  endtask

  initial begin
    int unsigned r0;
    void'($urandom(32'd20211));
    rst_n = 0; half_div = 8'd1; tmo_limit = 16'd0;
    cmd_valid = 0; cmd_wr_cnt = '0; cmd_rd_cnt = '0; cmd_last = 0;
    wr_data = '0; wr_valid = 0; rd_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    check(spi_cs_n == 1'b1, "R9", "cs_n", spi_cs_n, 1);
    check(spi_sclk == 1'b0, "R9", "sclk", spi_sclk, 0);
    check(cmd_ready == 1'b1, "R9", "cmd_ready", cmd_ready, 1);
    check(done == 1'b0 && rd_valid == 1'b0, "R9", "done/rd_valid", {done, rd_valid}, 0);

    // Directed: held chip select, stall with timeout off (R8 disabled case)
    half_div = 8'd1;
    run_sub(4, 0, 0, -1, 0, 16'h0, "R2");
    run_sub(2, 3, 1, 1, 80, 16'h0, "R8");
    check(high_len == 2, "R5", "sclk high length", high_len, 2);
    check(setup_len >= 2, "R4", "cs setup", setup_len, 2);
    check(hold_len >= 2, "R4", "cs hold", hold_len, 2);

    half_div = 8'd3;
    run_sub(1, 2, 1, -1, 0, 16'h0, "R10");
    check(high_len == 4, "R5", "sclk high length div3", high_len, 4);
    check(setup_len >= 4 && hold_len >= 4, "R4", "setup/hold div3", setup_len, 4);

    // R6: zero-size pieces
    half_div = 8'd0;
    run_sub(3, 0, 0, -1, 0, 16'h0, "R6");
    r0 = rises;
    run_sub(0, 0, 1, -1, 0, 16'h0, "R6");
    check(rises == r0 && spi_cs_n == 1'b1, "R6", "zero last releases only", int'(rises - r0), 0);
    run_sub(0, 0, 0, -1, 0, 16'h0, "R6");
    check(rises == r0 && spi_cs_n == 1'b1, "R6", "zero non-last idle", int'(rises - r0), 0);

    // R7: count screening, with chip select held beforehand
    run_sub(1, 0, 0, -1, 0, 16'h0, "R7");
    r0 = rises;
    run_sub(0, 61, 0, -1, 0, 16'h0004, "R7");
    run_sub(61, 0, 0, -1, 0, 16'h0003, "R7");
    run_sub(70, 70, 0, -1, 0, 16'h0004, "R7");
    check(rises == r0, "R7", "no clock on rejected counts", int'(rises - r0), 0);

    // R8: timeout while starved of write data, then recovery
    tmo_limit = 16'd300;
    run_sub(2, 0, 0, -1, 0, 16'h0, "R8");
    run_sub(3, 0, 0, 0, 100000, 16'h0001, "R8");
    check(spi_cs_n == 1'b1, "R8", "cs after timeout", spi_cs_n, 1);
    run_sub(2, 2, 1, -1, 0, 16'h0, "R8");
    tmo_limit = 16'd0;

    // Random multi-piece transactions
    for (int t = 0; t < 10; t++) begin
      int ns;
      half_div = 8'($urandom_range(0, 1));
      ns = $urandom_range(1, 3);
      for (int s = 0; s < ns; s++)
        run_sub($urandom_range(0, 60), $urandom_range(0, 60), s == ns - 1, -1, 0, 16'h0, "R10");
    end
    // Boundary: full 60-byte pieces
    run_sub(60, 0, 0, -1, 0, 16'h0, "R7");
    run_sub(0, 60, 1, -1, 0, 16'h0, "R7");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule